// File: doc/BRIEF.md
# Programmable Tap-Select Interval Timer

This block divides an input clock with a 16-bit binary prescale counter. A two-bit stage select picks which counter stage drives the output. A mode input chooses between two behaviours. In divider mode the output is a free-running square wave. In single-transition mode the output changes level once, a chosen number of counts after a reset. It then holds that level, and the counter stops, until the next reset. A polarity input can invert the output.

Reset sequencing covers two cases. By default a power-good input acts as a power-on reset: the block stays cleared while power-good is low and starts counting shortly after it rises. If the auto-reset disable input is high, the block instead waits idle after power-up until a master reset pulse has come and gone. An active-high master reset clears the block asynchronously at any time. A clock-enable output goes low while a reset is being applied, so that an external clock source can be stopped during that time.

Top module: `tap_interval_timer`

## Requirements
- R1: The counter is 16 bits wide and advances by one on each rising clock edge while running. After k counting edges since a reset it holds k.
- R2: The stage select {selB,selA} picks the driving stage as follows: 00 selects stage 13, 01 selects stage 10, 10 selects stage 8 and 11 selects stage 16. Stage N is counter bit N-1.
- R3: With modeDiv=1, the true output level equals the selected stage bit. It is low for the first 2^(N-1) counts after a reset and high for the next 2^(N-1), giving a square wave with period 2^N clocks.
- R4: With modeDiv=0, the true output level goes high when the count reaches 2^(N-1). The counter then stops and the level stays high until a reset.
- R5: Setting modeDiv to 1 after a single-transition hold releases the hold. Counting resumes from the frozen count on the next edge.
- R6: With outInvert=1, timerOut is the inverse of the true level. With outInvert=0, it equals the true level.
- R7: masterReset=1 clears the counter and the hold flag at once, without waiting for a clock edge. It keeps them cleared for as long as it stays high, overriding counting.
- R8: With autoResetDis=0, the block is held cleared while powerGood is low. The first rising edge after powerGood rises releases the reset, and the second rising edge is the first counting edge.
- R9: With autoResetDis=1, the counter stays at zero after powerGood rises. It does not count until masterReset has gone high and then low again.
- R10: clkEnable is 0 while masterReset is high, and 0 while the power-on reset is applied with autoResetDis=0. It is 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| powerGood | input | 1 | Power-good indication; low acts as power-on reset request |
| autoResetDis | input | 1 | 1 disables the power-on reset; counting then waits for a master reset pulse |
| masterReset | input | 1 | Asynchronous active-high clear |
| selA | input | 1 | Stage select, low bit |
| selB | input | 1 | Stage select, high bit |
| modeDiv | input | 1 | 1 gives divider mode, 0 gives single-transition mode |
| outInvert | input | 1 | 1 inverts the output |
| timerOut | output | 1 | Timer output |
| clkEnable | output | 1 | Low while a reset is being applied |

## Verification
When masterReset goes high, timerOut and clkEnable respond before the next clock edge. After masterReset is released, the first counting edge is the second rising edge, so a count of k is visible k+1 cycles after the cycle in which the reset was raised. The power-on release follows the same k+1 offset from the cycle in which powerGood rises. The scoreboard records the cycle in which each stimulus is applied. It queues every expected level at that base cycle plus the count offset, and compares each one at the falling edge of exactly that cycle. It brackets each transition by checking one cycle before it and the cycle in which it occurs.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  // Strobes from the control block to the datapath
  typedef struct packed {
    logic countEn;    // advance counter this edge
    logic clearHold;  // drop the single-transition hold flag
  } tmrStrobe_t;

  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_TAPS);
endpackage

// File: rtl/tap_timer_datapath.sv
module tap_timer_datapath
  import tap_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGE0 = 13,
  parameter int unsigned STAGE1 = 10,
  parameter int unsigned STAGE2 = 8,
  parameter int unsigned STAGE3 = 16
) (
  input  logic             clk,
  input  logic             clrAsync,
  input  tmrStrobe_t       strobe,
  input  logic [SEL_W-1:0] selCode,
  input  logic             modeDiv,
  input  logic             outInvert,
  output logic             trueLevel,
  output logic             timerOut
);
  localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

  logic [CNT_W-1:0]    cnt;
  logic                holdFlag;
  logic [NUM_TAPS-1:0] tapBits;
  logic                tapLevel;

  // One tap per selectable stage
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned STG = (g == 0) ? STAGE0 :
                                  (g == 1) ? STAGE1 :
                                  (g == 2) ? STAGE2 : STAGE3;
    assign tapBits[g] = cnt[STG-1];
  end

  assign tapLevel = tapBits[selCode];

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)            cnt <= '0;
    else if (strobe.countEn) cnt <= cnt + CNT_STEP;
  end

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)              holdFlag <= 1'b0;
    else if (strobe.clearHold) holdFlag <= 1'b0;
    else if (tapLevel)         holdFlag <= 1'b1;
  end

  assign trueLevel = modeDiv ? tapLevel : (holdFlag | tapLevel);
  assign timerOut  = trueLevel ^ outInvert;

  // R1: an enabled edge advances by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (clrAsync)
    strobe.countEn |=> cnt == $past(cnt) + CNT_STEP);
  // R1: no enable, no change
  a_r1_idle: assert property (@(posedge clk) disable iff (clrAsync)
    !strobe.countEn |=> $stable(cnt));
  // R4: hold flag is sticky while single-transition mode persists
  a_r4_hold_sticky: assert property (@(posedge clk) disable iff (clrAsync)
    (holdFlag && !strobe.clearHold) |=> holdFlag);
endmodule

// File: rtl/tap_timer_ctrl.sv
module tap_timer_ctrl
  import tap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       powerGood,
  input  logic       autoResetDis,
  input  logic       masterReset,
  input  logic       modeDiv,
  input  logic       trueLevel,
  output tmrStrobe_t strobe,
  output logic       clkEnable
);
  logic porDone;   // power-on reset released
  logic mrSeen;    // a master reset has been applied since power-up
  logic running;
  logic porHold;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) porDone <= 1'b0;
    else            porDone <= 1'b1;
  end

  always_ff @(posedge clk or negedge powerGood or posedge masterReset) begin
    if (!powerGood)       mrSeen <= 1'b0;
    else if (masterReset) mrSeen <= 1'b1;
    else                  mrSeen <= mrSeen;
  end

  assign running = autoResetDis ? mrSeen : porDone;
  assign porHold = !autoResetDis && !porDone;

  always_comb begin
    strobe.countEn   = running && !masterReset && (modeDiv || !trueLevel);
    strobe.clearHold = modeDiv;
  end

  assign clkEnable = !(masterReset || porHold);

  // R8: once released, the power-on reset stays released while power holds
  a_r8_por_sticky: assert property (@(posedge clk) disable iff (!powerGood)
    porDone |=> porDone);
  // R9: with auto reset off, nothing counts before a master reset
  a_r9_wait_mr: assert property (@(posedge clk) disable iff (!powerGood)
    (autoResetDis && !mrSeen) |-> !strobe.countEn);
  // R10: the clock source is gated during master reset
  a_r10_gate: assert property (@(posedge clk)
    masterReset |-> !clkEnable);
endmodule

// File: rtl/tap_interval_timer.sv
module tap_interval_timer
  import tap_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGE0 = 13,
  parameter int unsigned STAGE1 = 10,
  parameter int unsigned STAGE2 = 8,
  parameter int unsigned STAGE3 = 16
) (
  input  logic clk,
  input  logic powerGood,
  input  logic autoResetDis,
  input  logic masterReset,
  input  logic selA,
  input  logic selB,
  input  logic modeDiv,
  input  logic outInvert,
  output logic timerOut,
  output logic clkEnable
);
  tmrStrobe_t       strobe;
  logic             trueLevel;
  logic             clrAsync;
  logic [SEL_W-1:0] selCode;

  assign clrAsync = masterReset || !powerGood;
  assign selCode  = {selB, selA};

  tap_timer_ctrl u_ctrl (
    .clk          (clk),
    .powerGood    (powerGood),
    .autoResetDis (autoResetDis),
    .masterReset  (masterReset),
    .modeDiv      (modeDiv),
    .trueLevel    (trueLevel),
    .strobe       (strobe),
    .clkEnable    (clkEnable)
  );

  tap_timer_datapath #(
    .CNT_W  (CNT_W),
    .STAGE0 (STAGE0),
    .STAGE1 (STAGE1),
    .STAGE2 (STAGE2),
    .STAGE3 (STAGE3)
  ) u_dp (
    .clk       (clk),
    .clrAsync  (clrAsync),
    .strobe    (strobe),
    .selCode   (selCode),
    .modeDiv   (modeDiv),
    .outInvert (outInvert),
    .trueLevel (trueLevel),
    .timerOut  (timerOut)
  );

  // R4: in single-transition mode a high level never drops without reset
  a_r4_no_retoggle: assert property (@(posedge clk) disable iff (clrAsync)
    (!modeDiv && trueLevel) |=> (modeDiv || trueLevel));
  // R7: the output polarity follows the true level after a clear
  a_r7_clear_low: assert property (@(posedge clk)
    (masterReset && !modeDiv) |-> (timerOut == outInvert));
endmodule

// File: tb/sim_tap_interval_timer.sv
module sim_tap_interval_timer;
  logic clk = 1'b0;
  logic powerGood = 1'b0, autoResetDis = 1'b0, masterReset = 1'b0;
  logic selA = 1'b0, selB = 1'b1, modeDiv = 1'b1, outInvert = 1'b0;
  logic timerOut, clkEnable;

  tap_interval_timer u0 (
    .clk(clk), .powerGood(powerGood), .autoResetDis(autoResetDis),
    .masterReset(masterReset), .selA(selA), .selB(selB),
    .modeDiv(modeDiv), .outInvert(outInvert),
    .timerOut(timerOut), .clkEnable(clkEnable)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  outV;
    bit    chkCe;
    logic  ceV;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // Monitor: compares queued expectations at the falling edge of their cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      nChecks++;
      if (it.at < cyc) begin
        nFails++;
        $display("FAIL %s: check for cycle %0d missed (actual cycle %0d, expected %0d)",
                 it.tag, it.at, cyc, it.at);
      end else begin
        if (timerOut !== it.outV) begin
          nFails++;
          $display("FAIL %s: cycle %0d timerOut=%b expected %b", it.tag, cyc, timerOut, it.outV);
        end
        if (it.chkCe && clkEnable !== it.ceV) begin
          nFails++;
          $display("FAIL %s: cycle %0d clkEnable=%b expected %b", it.tag, cyc, clkEnable, it.ceV);
        end
      end
    end
  end

  task automatic waitCyc(input int target);
    while (cyc < target) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expectAt(input int at, input logic trueLvl, input bit chkCe,
                          input logic ceV, input string tag);
    expItem_t it;
    it.at = at; it.outV = trueLvl ^ outInvert; it.chkCe = chkCe; it.ceV = ceV; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Master reset pulse over one rising edge; count k appears at base+k
  task automatic pulseMr(output int base);
    int c0;
    c0 = cyc;
    masterReset = 1'b1;
    expectAt(c0, 1'b0, 1'b1, 1'b0, "R7 R10 immediate clear");
    @(posedge clk); #1;
    masterReset = 1'b0;
    base = c0 + 1;
    expectAt(base, 1'b0, 1'b1, 1'b1, "R10 released");
  endtask

  initial begin
    int base, p, q;
    // Reset state: power low, auto reset enabled
    waitCyc(3);
    expectAt(3, 1'b0, 1'b1, 1'b0, "R8 R10 held in power-on reset");
    waitCyc(4);
    powerGood = 1'b1; p = cyc;
    expectAt(p, 1'b0, 1'b1, 1'b0, "R8 release takes one edge");
    base = p + 1;
    expectAt(base, 1'b0, 1'b1, 1'b1, "R8 R10 enable after release");
    // R3 stage 8 divider (select 10)
    expectAt(base + 127, 1'b0, 1'b0, 1'b0, "R3 R8 stage8 low before 128");
    expectAt(base + 128, 1'b1, 1'b0, 1'b0, "R3 R8 stage8 high at 128");
    expectAt(base + 255, 1'b1, 1'b0, 1'b0, "R3 stage8 high at 255");
    expectAt(base + 256, 1'b0, 1'b0, 1'b0, "R3 R1 stage8 low at 256");
    expectAt(base + 384, 1'b1, 1'b0, 1'b0, "R3 R1 stage8 high at 384");
    waitCyc(base + 400);
    // R7: output is high here; pulse clears it before any edge
    pulseMr(base);

    // R2 stage 10 (select 01)
    waitCyc(base + 20);
    selB = 1'b0; selA = 1'b1;
    pulseMr(base);
    expectAt(base + 511, 1'b0, 1'b0, 1'b0, "R2 R3 stage10 low at 511");
    expectAt(base + 512, 1'b1, 1'b0, 1'b0, "R2 R3 stage10 high at 512");
    expectAt(base + 1023, 1'b1, 1'b0, 1'b0, "R3 stage10 high at 1023");
    expectAt(base + 1024, 1'b0, 1'b0, 1'b0, "R3 stage10 low at 1024");
    waitCyc(base + 1030);

    // R2 stage 13 (select 00)
    selB = 1'b0; selA = 1'b0;
    pulseMr(base);
    expectAt(base + 4095, 1'b0, 1'b0, 1'b0, "R2 stage13 low at 4095");
    expectAt(base + 4096, 1'b1, 1'b0, 1'b0, "R2 R3 stage13 high at 4096");
    expectAt(base + 8192, 1'b0, 1'b0, 1'b0, "R3 stage13 low at 8192");
    waitCyc(base + 8200);

    // R4 single transition, stage 8
    selB = 1'b1; selA = 1'b0; modeDiv = 1'b0;
    pulseMr(base);
    expectAt(base + 127, 1'b0, 1'b0, 1'b0, "R4 low before 128");
    expectAt(base + 128, 1'b1, 1'b0, 1'b0, "R4 high at 128");
    expectAt(base + 300, 1'b1, 1'b0, 1'b0, "R4 held, counter frozen");
    waitCyc(base + 310);
    outInvert = 1'b1;
    expectAt(cyc, 1'b1, 1'b0, 1'b0, "R6 inverted hold");
    waitCyc(base + 320);
    outInvert = 1'b0;
    expectAt(cyc, 1'b1, 1'b0, 1'b0, "R6 true hold");
    waitCyc(base + 330);
    modeDiv = 1'b1; q = cyc;
    expectAt(q, 1'b1, 1'b0, 1'b0, "R5 level kept on switch");
    expectAt(q + 127, 1'b1, 1'b0, 1'b0, "R5 resumed from 128");
    expectAt(q + 128, 1'b0, 1'b0, 1'b0, "R5 resumed reaches 256");
    waitCyc(q + 140);

    // R4 stage 16 single transition (select 11)
    selB = 1'b1; selA = 1'b1; modeDiv = 1'b0;
    pulseMr(base);
    expectAt(base + 32767, 1'b0, 1'b0, 1'b0, "R2 R4 stage16 low at 32767");
    expectAt(base + 32768, 1'b1, 1'b0, 1'b0, "R1 R2 R4 stage16 high at 32768");
    expectAt(base + 32800, 1'b1, 1'b0, 1'b0, "R4 stage16 held");
    waitCyc(base + 32810);

    // R6 inverted divider, stage 8
    selB = 1'b1; selA = 1'b0; modeDiv = 1'b1; outInvert = 1'b1;
    pulseMr(base);
    expectAt(base + 127, 1'b0, 1'b0, 1'b0, "R6 inverted low level");
    expectAt(base + 128, 1'b1, 1'b0, 1'b0, "R6 inverted high level");
    waitCyc(base + 140);
    outInvert = 1'b0;

    // R9 auto reset disabled: power cycle, no counting until master pulse
    autoResetDis = 1'b1;
    powerGood = 1'b0;
    expectAt(cyc, 1'b0, 1'b1, 1'b1, "R9 R10 power drop, no auto hold");
    waitCyc(cyc + 3);
    powerGood = 1'b1; p = cyc;
    expectAt(p + 1, 1'b0, 1'b1, 1'b1, "R10 enable while waiting");
    expectAt(p + 200, 1'b0, 1'b1, 1'b1, "R9 idle at 200");
    expectAt(p + 300, 1'b0, 1'b1, 1'b1, "R9 idle at 300");
    waitCyc(p + 310);
    pulseMr(base);
    expectAt(base + 127, 1'b0, 1'b0, 1'b0, "R9 counts after pulse, 127");
    expectAt(base + 128, 1'b1, 1'b0, 1'b0, "R9 counts after pulse, 128");
    waitCyc(base + 140);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: cycle %0d reached, expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule